// File: doc/BRIEF.md
# Eight-Channel APB Timer with PWM Outputs

This peripheral hangs on an APB bus and holds eight independent down-counters. Software writes a start value and a compare threshold into per-channel holding registers. Those values reach the live counter only when the channel's control word is written with its load bit set, so a running channel can have its next period staged without disturbing the current one. A channel counts either on every bus clock or on rising edges of its own external tick pin. When it runs out, it either stops or refills from its holding register and keeps going.

Each channel raises a flag in a common status word when it runs out with its interrupt enable set. Software clears a flag by writing a one to its bit, and a single interrupt line is high whenever any flag is set. Every channel also drives a PWM pin. The pin is high while the live count is above the loaded compare value, so the start value sets the period and the compare value sets the duty cycle.

Top module: `pwm_timer_apb`

## Requirements
- R1: Only word-aligned accesses are decoded (address bits 1:0 zero). Offset 0x00 is the status word, offsets 0x04 to 0x0C read zero, and channel N occupies 0x10+16N: control at +0, count holding at +4, compare holding at +8 and live count at +0xC. A constant revision word sits at 0x90. The holding registers read back what was written. Control reads back bit 0 external tick, bit 1 run, bit 2 load pending, bit 4 auto-reload and bit 5 interrupt enable, with all other bits zero. Writes to the live count or the revision word have no effect.
- R2: Writing control with bit 2 set copies both holding registers into the live counter and live compare on the following clock, and bit 2 then reads 0. Writing a holding register alone leaves the live count unchanged.
- R3: A running channel with bit 0 clear decrements its live count by one on each clock, starting the clock after the run bit is written. The live-count register returns the current value. Writing control with bit 1 clear stops the channel and the count holds.
- R4: A channel expires on the tick that brings its count from 1 to 0, or on any tick at 0. Without auto-reload it then clears its run bit, so a channel loaded with N≥1 expires N ticks after the load.
- R5: With auto-reload set, an expiring channel reloads the count holding value and keeps running, so it expires every N ticks.
- R6: An expiry sets status bit N for channel N only if that channel's interrupt enable (control bit 5) is set.
- R7: Writing 1 to a status bit clears it and leaves bits written with 0 untouched. A set in the same cycle wins over a clear. The interrupt output is high exactly when any status bit is set.
- R8: A channel's PWM output is high while it is running and its live count is greater than its live compare value, and low otherwise.
- R9: With control bit 0 set, the external tick pin is passed through a two-flop synchroniser and the count decrements once per rising edge, however long the pin stays high.
- R10: After reset, all registers, flags, the interrupt and all PWM outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W (8) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| ext_tick | input | NUM_CH (8) | Asynchronous external tick per channel |
| irq | output | 1 | OR of all status flags |
| pwm_out | output | NUM_CH (8) | PWM output per channel |

## Verification
A table of writes followed by read-backs covers the holding registers, the control bits, the reserved words, the revision word and the ignored writes. These entries separate real storage from decode aliasing and show which control bits are kept and which are dropped. Counting is then exercised with a one-shot load, an auto-reload load, a run with the interrupt disabled, a stopped load, a free run that is halted, and an external tick pin held high for many cycles. The interrupt edge is sampled in the exact expected cycle, which exposes off-by-one expiry and load latency. Clear patterns that leave one flag standing while another is removed separate per-bit write-one-to-clear from a whole-word clear. Sampling the PWM pin just before and just after the count meets the compare value pins down the strict greater-than comparison.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    localparam int DATA_W  = 32;
    localparam int BIT_EXT = 0;
    localparam int BIT_RUN = 1;
    localparam int BIT_UPD = 2;
    localparam int BIT_ARL = 4;
    localparam int BIT_IE  = 5;

    typedef enum logic [1:0] {
        W_CTRL = 2'd0,
        W_CNTB = 2'd1,
        W_CMPB = 2'd2,
        W_OBS  = 2'd3
    } word_e;

    typedef struct packed {
        logic ie;
        logic arl;
        logic ext;
        logic run;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.ie  = w[BIT_IE];
        c.arl = w[BIT_ARL];
        c.ext = w[BIT_EXT];
        c.run = w[BIT_RUN];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic upd);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[BIT_IE]  = c.ie;
        w[BIT_ARL] = c.arl;
        w[BIT_EXT] = c.ext;
        w[BIT_RUN] = c.run;
        w[BIT_UPD] = upd;
        return w;
    endfunction

endpackage

// File: rtl/ptm_tick_sync.sv
module ptm_tick_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;

    // R9: one decrement per edge, never two in a row
    assert_single_tick_R9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/ptm_channel.sv
module ptm_channel
    import ptm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_cntb,
    input  logic              wr_cmpb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_rise,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]  cntb_rd,
    output logic [CNT_W-1:0]  cmpb_rd,
    output logic [CNT_W-1:0]  cnt_rd,
    output logic              pwm,
    output logic              flag_set
);
    ctrl_t            ctrl_q;
    logic             upd_q;
    logic [CNT_W-1:0] cnt_q, cntb_q, cmpb_q, cmp_live_q;
    logic             tick, expire;

    assign tick   = ctrl_q.run && !upd_q && (ctrl_q.ext ? ext_rise : 1'b1);
    assign expire = tick && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            upd_q      <= 1'b0;
            cnt_q      <= '0;
            cntb_q     <= '0;
            cmpb_q     <= '0;
            cmp_live_q <= '0;
        end else begin
            if (upd_q) begin
                cnt_q      <= cntb_q;
                cmp_live_q <= cmpb_q;
                upd_q      <= 1'b0;
            end else if (expire) begin
                if (ctrl_q.arl) begin
                    cnt_q      <= cntb_q;
                    cmp_live_q <= cmpb_q;
                end else begin
                    cnt_q      <= '0;
                    ctrl_q.run <= 1'b0;
                end
            end else if (tick) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (wr_cntb) cntb_q <= wdata[CNT_W-1:0];
            if (wr_cmpb) cmpb_q <= wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                ctrl_q <= unpack_ctrl(wdata);
                upd_q  <= wdata[BIT_UPD];
            end
        end
    end

    assign ctrl_rd  = pack_ctrl(ctrl_q, upd_q);
    assign cntb_rd  = cntb_q;
    assign cmpb_rd  = cmpb_q;
    assign cnt_rd   = cnt_q;
    assign pwm      = ctrl_q.run && (cnt_q > cmp_live_q);
    assign flag_set = expire && ctrl_q.ie;

    // R2: load request lasts exactly one clock
    assert_upd_selfclear_R2: assert property (@(posedge clk) disable iff (rst)
        (upd_q && !wr_ctrl) |=> !upd_q);
    // R3: a stopped channel keeps its count
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !upd_q) |=> $stable(cnt_q));
    // R4: one-shot channel stops after expiry
    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.arl && !wr_ctrl) |=> !ctrl_q.run);
    // R5: auto-reload refills from the holding register
    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.arl && !wr_cntb) |=> (cnt_q == $past(cntb_q)));
endmodule

// File: rtl/pwm_timer_apb.sv
module pwm_timer_apb
    import ptm_pkg::*;
#(
    parameter int          NUM_CH   = 8,
    parameter int          CNT_W    = 32,
    parameter logic [31:0] REVISION = 32'h0001_0A00,
    localparam int         ADDR_W   = $clog2((NUM_CH + 2) * 16)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NUM_CH-1:0] ext_tick,
    output logic              irq,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int BLK_W   = ADDR_W - 4;
    localparam int REV_BLK = NUM_CH + 1;

    logic [BLK_W-1:0] blk;
    word_e            word;
    logic             aligned, wr_en, wr_status;
    logic [NUM_CH-1:0] flags_q, set_v, clr_v, rise_v;
    logic [NUM_CH-1:0] wr_ctrl, wr_cntb, wr_cmpb;
    logic [DATA_W-1:0] ctrl_rd [NUM_CH];
    logic [CNT_W-1:0]  cntb_rd [NUM_CH];
    logic [CNT_W-1:0]  cmpb_rd [NUM_CH];
    logic [CNT_W-1:0]  cnt_rd  [NUM_CH];
    logic [31:0]       rd_mux;

    assign blk       = paddr[ADDR_W-1:4];
    assign word      = word_e'(paddr[3:2]);
    assign aligned   = (paddr[1:0] == 2'b00);
    assign wr_en     = psel && penable && pwrite && aligned;
    assign wr_status = wr_en && (blk == '0) && (word == W_CTRL);
    assign clr_v     = wr_status ? pwdata[NUM_CH-1:0] : '0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit        = wr_en && (blk == BLK_W'(i + 1));
        assign wr_ctrl[i] = hit && (word == W_CTRL);
        assign wr_cntb[i] = hit && (word == W_CNTB);
        assign wr_cmpb[i] = hit && (word == W_CMPB);

        ptm_tick_sync u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (ext_tick[i]),
            .rise (rise_v[i])
        );

        ptm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (wr_ctrl[i]),
            .wr_cntb  (wr_cntb[i]),
            .wr_cmpb  (wr_cmpb[i]),
            .wdata    (pwdata),
            .ext_rise (rise_v[i]),
            .ctrl_rd  (ctrl_rd[i]),
            .cntb_rd  (cntb_rd[i]),
            .cmpb_rd  (cmpb_rd[i]),
            .cnt_rd   (cnt_rd[i]),
            .pwm      (pwm_out[i]),
            .flag_set (set_v[i])
        );

        // R6: an enabled expiry always leaves its flag set
        assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
            set_v[i] |=> flags_q[i]);
        // R7: a one written without a competing set clears the flag
        assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_status && pwdata[i] && !set_v[i]) |=> !flags_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_v) | set_v;
    end

    assign irq = |flags_q;

    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            if (blk == '0) begin
                if (word == W_CTRL) rd_mux = 32'(flags_q);
            end else if (blk == BLK_W'(REV_BLK)) begin
                if (word == W_CTRL) rd_mux = REVISION;
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (blk == BLK_W'(i + 1)) begin
                        case (word)
                            W_CTRL:  rd_mux = ctrl_rd[i];
                            W_CNTB:  rd_mux = 32'(cntb_rd[i]);
                            W_CMPB:  rd_mux = 32'(cmpb_rd[i]);
                            default: rd_mux = 32'(cnt_rd[i]);
                        endcase
                    end
                end
            end
        end
    end

    assign prdata = (psel && !pwrite) ? rd_mux : '0;
endmodule

// File: tb/tb_pwm_timer_apb.sv
module tb_pwm_timer_apb;
    localparam logic [31:0] REV = 32'h0001_0A00;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic [7:0]  ext_tick;
    logic        irq;
    logic [7:0]  pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_timer_apb dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick(ext_tick),
        .irq(irq), .pwm_out(pwm_out)
    );

    // {address, write data, expected read-back}
    localparam logic [71:0] VECS [0:8] = '{
        {8'h64, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {8'h68, 32'h1234_5678, 32'h1234_5678},
        {8'h74, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {8'h78, 32'h0000_0000, 32'h0000_0000},
        {8'h60, 32'h0000_0031, 32'h0000_0031},
        {8'h7C, 32'h0000_ABCD, 32'h0000_0000},
        {8'h90, 32'h0000_0000, REV},
        {8'h04, 32'h0000_FFFF, 32'h0000_0000},
        {8'h80, 32'hFFFF_FFC8, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, v1;
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; ext_tick = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 irq", {31'b0, irq}, 32'h0);
        check("R10 pwm", {24'b0, pwm_out}, 32'h0);
        apb_read(8'h00, rd); check("R10 status", rd, 32'h0);
        apb_read(8'h10, rd); check("R10 ctrl0", rd, 32'h0);
        apb_read(8'h1C, rd); check("R10 obs0", rd, 32'h0);

        // R1 register map table
        for (int i = 0; i < 9; i++) begin
            apb_write(VECS[i][71:64], VECS[i][63:32]);
            apb_read(VECS[i][71:64], rd);
            check($sformatf("R1 vec%0d", i), rd, VECS[i][31:0]);
        end

        // R4 R6: one-shot, count 5, ie+upd+run
        apb_write(8'h14, 32'd5);
        apb_write(8'h10, 32'h26);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R4 irq before expiry", {31'b0, irq}, 32'h0);
        end
        @(negedge clk);
        check("R4 irq at expiry", {31'b0, irq}, 32'h1);
        apb_read(8'h10, rd); check("R4 run cleared", rd, 32'h20);
        apb_read(8'h00, rd); check("R6 status bit0", rd, 32'h1);
        apb_write(8'h00, 32'h1);
        check("R7 irq after clear", {31'b0, irq}, 32'h0);
        apb_read(8'h00, rd); check("R7 status cleared", rd, 32'h0);

        // R5: auto-reload, count 3
        apb_write(8'h24, 32'd3);
        apb_write(8'h20, 32'h36);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 irq before first expiry", {31'b0, irq}, 32'h0);
        end
        @(negedge clk);
        check("R5 irq first expiry", {31'b0, irq}, 32'h1);
        apb_read(8'h20, rd); check("R5 still running", rd, 32'h32);
        apb_write(8'h00, 32'h2);
        repeat (4) @(negedge clk);
        apb_read(8'h00, rd); check("R5 expires again", rd, 32'h2);
        apb_write(8'h20, 32'h0);
        apb_read(8'h2C, v1);
        repeat (5) @(negedge clk);
        apb_read(8'h2C, rd); check("R3 stop holds count", rd, v1);

        // R7: flag0 set with flag1 standing; clear only bit0
        apb_write(8'h14, 32'd0);
        apb_write(8'h10, 32'h26);
        repeat (4) @(negedge clk);
        apb_read(8'h00, rd); check("R7 two flags", rd, 32'h3);
        apb_write(8'h00, 32'h1);
        apb_read(8'h00, rd); check("R7 other bit kept", rd, 32'h2);
        check("R7 irq while bit1 set", {31'b0, irq}, 32'h1);
        apb_write(8'h00, 32'h2);
        check("R7 irq all clear", {31'b0, irq}, 32'h0);

        // R6: expiry with interrupt disabled
        apb_write(8'h34, 32'd2);
        apb_write(8'h30, 32'h06);
        repeat (10) @(negedge clk);
        apb_read(8'h00, rd); check("R6 no flag when disabled", rd, 32'h0);
        apb_read(8'h30, rd); check("R4 ie-off channel stopped", rd, 32'h0);

        // R2: load while stopped, self-clearing bit
        apb_write(8'h34, 32'd100);
        apb_write(8'h30, 32'h04);
        apb_read(8'h30, rd); check("R2 load bit reads 0", rd, 32'h0);
        apb_read(8'h3C, rd); check("R2 live count loaded", rd, 32'd100);
        apb_write(8'h34, 32'd7);
        apb_read(8'h3C, rd); check("R2 holding write not live", rd, 32'd100);

        // R3: free run decrements every clock
        apb_write(8'h30, 32'h02);
        apb_read(8'h3C, rd); check("R3 count after two clocks", rd, 32'd98);
        apb_write(8'h30, 32'h00);
        apb_read(8'h3C, v1);
        repeat (5) @(negedge clk);
        apb_read(8'h3C, rd); check("R3 halted count", rd, v1);

        // R8: PWM, count 10, compare 4
        apb_write(8'h44, 32'd10);
        apb_write(8'h48, 32'd4);
        apb_write(8'h40, 32'h16);
        check("R8 pwm low before load", {31'b0, pwm_out[3]}, 32'h0);
        @(negedge clk);
        check("R8 pwm high at 10", {31'b0, pwm_out[3]}, 32'h1);
        repeat (5) @(negedge clk);
        check("R8 pwm high at 5", {31'b0, pwm_out[3]}, 32'h1);
        @(negedge clk);
        check("R8 pwm low at 4", {31'b0, pwm_out[3]}, 32'h0);
        apb_write(8'h40, 32'h0);
        check("R8 pwm low when stopped", {31'b0, pwm_out[3]}, 32'h0);

        // R9: external tick, count 2
        apb_write(8'h54, 32'd2);
        apb_write(8'h50, 32'h07);
        repeat (10) @(negedge clk);
        apb_read(8'h5C, rd); check("R9 no tick no count", rd, 32'd2);
        ext_tick[4] = 1'b1;
        repeat (10) @(negedge clk);
        apb_read(8'h5C, rd); check("R9 one decrement per edge", rd, 32'd1);
        ext_tick[4] = 1'b0;
        repeat (5) @(negedge clk);
        ext_tick[4] = 1'b1;
        repeat (10) @(negedge clk);
        apb_read(8'h50, rd); check("R9 expired on second edge", rd, 32'h01);
        apb_read(8'h5C, rd); check("R9 count zero", rd, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule